// File: doc/BRIEF.md
# Scaled CIC Decimator

This block lowers the sample rate of a 2's-complement stream with a cascaded integrator-comb filter whose order is fixed at build time to either 2 or 5. Each accepted input sample is first shifted down arithmetically by a programmable amount. It then passes through a chain of integrators that run at the input rate. Once every programmed number of accepted samples, the newest integrator sum goes through a chain of comb sections. These run at the decimated rate and use a differential delay of one. The result leaves the block with a one-cycle valid strobe.

The down-shift and the decimation rate come from two configuration inputs. The shift trades output magnitude for headroom. The largest shift and the largest rate that the block honours depend on the order, and any larger programmed value is clamped to that limit. The accumulators are wide enough to hold the full growth at the largest legal rate, so modular 2's-complement arithmetic in the integrators always gives an exact result. A synchronous reset clears every integrator, every comb delay and the sample counter.

Top module: `cic_decim`

## Requirements
- R1: While `rst` is high, and afterwards until the first output, `out_valid` is 0 and `out_data` is 0. Reset clears all history, so outputs after a reset depend only on samples accepted after it.
- R2: Each accepted sample is sign-extended and arithmetically shifted right by the effective scale, rounding toward minus infinity, before it enters the first integrator. `cfg_scale` is a 5-bit unsigned value.
- R3: The effective scale is `cfg_scale`, clamped to 6 when ORDER is 2 and to 20 when ORDER is 5.
- R4: Let R be the effective decimation. Counting accepted samples from reset, the sample numbered k·R (k ≥ 1) makes `out_valid` high for the one cycle after the clock edge that accepts it. No other cycle has `out_valid` high. R = 1 gives one output per sample.
- R5: `cfg_rate_m1` is an 8-bit unsigned value holding the rate minus one. The effective decimation R is `cfg_rate_m1`+1, clamped to 16 when ORDER is 2 and to 32 when ORDER is 5.
- R6: Let s[i] be the shifted samples, with s[i] = 0 for i < 0. Let h be the coefficients of (1 + z^-1 + … + z^-(R-1))^ORDER. Then output number k (k ≥ 1) equals the sum over j of h[j]·s[kR−1−j]. It is given as a 2's-complement value of IN_W + ORDER·log2(RMAX) bits, where RMAX is the clamp limit of R5.
- R7: In cycles where `in_valid` is low, `in_data` has no effect on any later output.
- R8: `out_data` changes only in cycles where `out_valid` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | 2's-complement input sample |
| cfg_scale | input | SCALE_W | Pre-integration down-shift amount |
| cfg_rate_m1 | input | RATE_W | Decimation rate minus one |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | IN_W+ORDER·log2(RMAX) | 2's-complement decimated sample |

## Verification
The main function is tried with several input patterns, each at a number of rates and shifts. A constant input at full-scale positive and full-scale negative values drives the accumulators to the edge of their width at the largest rate, which shows whether the DC gain R^ORDER and the wrap behaviour are exact. A single impulse shows the shape of the impulse response. An alternating sign pattern and a pseudo-random sequence expose errors in comb ordering, in stage coupling and in the floor rounding of negative shifted samples. Idle gaps with garbage data on the bus, out-of-range shift and rate values, a rate of one, and a reset in the middle of a run separate the handling of valid strobes, clamping and reset from the filter arithmetic.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Largest down-shift honoured for a given filter order.
  function automatic int scale_max(input int order);
    return (order == 2) ? 6 : 20;
  endfunction

  // Largest decimation honoured for a given filter order.
  function automatic int rate_max(input int order);
    return (order == 2) ? 16 : 32;
  endfunction

  // Clamp an unsigned configuration value to a limit.
  function automatic int sat(input int value, input int limit);
    return (value > limit) ? limit : value;
  endfunction

endpackage

// File: rtl/cic_prescale.sv
module cic_prescale #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 41,
  parameter int SH_W  = 5
) (
  input  logic [IN_W-1:0]  x,
  input  logic [SH_W-1:0]  sh,
  output logic [ACC_W-1:0] xs
);
  logic [ACC_W-1:0] ext;

  assign ext = {{(ACC_W-IN_W){x[IN_W-1]}}, x};
  assign xs  = $signed(ext) >>> sh;

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int ORDER = 5,
  parameter int ACC_W = 41
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] xs,
  output logic [ACC_W-1:0] sum_next
);
  logic [ACC_W-1:0] acc [ORDER];
  logic [ACC_W-1:0] nxt [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign nxt[k] = acc[k] + xs;
    end else begin : g_rest
      assign nxt[k] = acc[k] + nxt[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst)     acc[k] <= '0;
      else if (en) acc[k] <= nxt[k];
    end
  end

  assign sum_next = nxt[ORDER-1];

endmodule

// File: rtl/cic_decim_ctrl.sv
module cic_decim_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] rate_eff,
  output logic             dump,
  output logic [CNT_W-1:0] cnt
);
  assign dump = in_valid && (cnt >= rate_eff);

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (in_valid) cnt <= dump ? '0 : cnt + CNT_W'(1);
  end

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int ORDER = 5,
  parameter int ACC_W = 41
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dump,
  input  logic [ACC_W-1:0] din,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_data
);
  logic [ACC_W-1:0] dly [ORDER];
  logic [ACC_W-1:0] dif [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign dif[k] = din - dly[k];
      always_ff @(posedge clk) begin
        if (rst)       dly[k] <= '0;
        else if (dump) dly[k] <= din;
      end
    end else begin : g_rest
      assign dif[k] = dif[k-1] - dly[k];
      always_ff @(posedge clk) begin
        if (rst)       dly[k] <= '0;
        else if (dump) dly[k] <= dif[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= dump;
      if (dump) out_data <= dif[ORDER-1];
    end
  end

endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter int ORDER   = 5,
  parameter int IN_W    = 16,
  parameter int SCALE_W = 5,
  parameter int RATE_W  = 8,
  localparam int SMAX   = scale_max(ORDER),
  localparam int RMAX   = rate_max(ORDER),
  localparam int SH_W   = $clog2(SMAX + 1),
  localparam int CNT_W  = $clog2(RMAX),
  localparam int ACC_W  = IN_W + ORDER * CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [IN_W-1:0]    in_data,
  input  logic [SCALE_W-1:0] cfg_scale,
  input  logic [RATE_W-1:0]  cfg_rate_m1,
  output logic               out_valid,
  output logic [ACC_W-1:0]   out_data
);
  logic [SH_W-1:0]  sh_eff;
  logic [CNT_W-1:0] rate_eff;
  logic [ACC_W-1:0] xs_w;
  logic [ACC_W-1:0] isum_w;
  logic             dump_w;
  logic [CNT_W-1:0] cnt_w;

  assign sh_eff   = SH_W'(sat(int'(cfg_scale), SMAX));
  assign rate_eff = CNT_W'(sat(int'(cfg_rate_m1), RMAX - 1));

  cic_prescale #(.IN_W(IN_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_pre (
    .x  (in_data),
    .sh (sh_eff),
    .xs (xs_w)
  );

  cic_integ_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk      (clk),
    .rst      (rst),
    .en       (in_valid),
    .xs       (xs_w),
    .sum_next (isum_w)
  );

  cic_decim_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .rate_eff (rate_eff),
    .dump     (dump_w),
    .cnt      (cnt_w)
  );

  cic_comb_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk       (clk),
    .rst       (rst),
    .dump      (dump_w),
    .din       (isum_w),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
  parameter int ACC_W = 41,
  parameter int CNT_W = 5,
  parameter int RMAX  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_sign,
  input logic             xs_sign,
  input logic             dump,
  input logic [CNT_W-1:0] cnt,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_data
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R2
  shift_sign_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (xs_sign == in_sign));

  // R4
  dump_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    dump |=> out_valid);

  // R4
  out_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(dump));

  // R4
  count_restart_chk: assert property (@(posedge clk) disable iff (rst)
    dump |=> (cnt == '0));

  // R5
  rate_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt == CNT_W'(RMAX - 1)) |-> dump);

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

endmodule

bind cic_decim cic_decim_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W), .RMAX(RMAX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_sign   (in_data[IN_W-1]),
  .xs_sign   (xs_w[ACC_W-1]),
  .dump      (dump_w),
  .cnt       (cnt_w),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/cic_decim_test.sv
`timescale 1ns/1ps
module cic_decim_test;
  localparam int A5 = 41;
  localparam int A2 = 24;
  localparam int NOUT = 5;

  typedef struct packed {
    logic        o2;
    logic [7:0]  rm1;
    logic [4:0]  sc;
    logic [1:0]  pat;   // 0 dc, 1 impulse, 2 alternating, 3 pseudo-random
    logic        gap;
    logic [15:0] amp;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b0, 8'd3,   5'd0,  2'd0, 1'b0, 16'd1000},
    '{1'b0, 8'd7,   5'd2,  2'd1, 1'b0, 16'd20000},
    '{1'b0, 8'd31,  5'd0,  2'd0, 1'b0, 16'h7FFF},
    '{1'b0, 8'd31,  5'd0,  2'd0, 1'b0, 16'h8000},
    '{1'b0, 8'd5,   5'd3,  2'd3, 1'b1, 16'h1234},
    '{1'b0, 8'd9,   5'd31, 2'd3, 1'b0, 16'hBEEF},
    '{1'b0, 8'd255, 5'd20, 2'd0, 1'b0, 16'h8000},
    '{1'b1, 8'd15,  5'd0,  2'd0, 1'b0, 16'h7FFF},
    '{1'b1, 8'd4,   5'd1,  2'd2, 1'b0, 16'd12345},
    '{1'b1, 8'd200, 5'd2,  2'd3, 1'b1, 16'h5A5A},
    '{1'b1, 8'd2,   5'd9,  2'd1, 1'b0, 16'h8000},
    '{1'b0, 8'd0,   5'd4,  2'd3, 1'b0, 16'h0F0F},
    '{1'b1, 8'd7,   5'd6,  2'd2, 1'b0, 16'h8000}
  };

  function automatic string vec_tag(input int v);
    case (v)
      1, 8, 12: return "R2";
      4:        return "R7";
      5, 10:    return "R3";
      6, 9:     return "R5";
      11:       return "R4";
      default:  return "R6";
    endcase
  endfunction

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          v5 = 1'b0, v2 = 1'b0;
  logic [15:0]   din = '0;
  logic [4:0]    sc = '0;
  logic [7:0]    rm = '0;
  logic          ov5, ov2;
  logic [A5-1:0] od5;
  logic [A2-1:0] od2;

  cic_decim #(.ORDER(5)) uut (
    .clk(clk), .rst(rst), .in_valid(v5), .in_data(din),
    .cfg_scale(sc), .cfg_rate_m1(rm), .out_valid(ov5), .out_data(od5));

  cic_decim #(.ORDER(2)) uut_o2 (
    .clk(clk), .rst(rst), .in_valid(v2), .in_data(din),
    .cfg_scale(sc), .cfg_rate_m1(rm), .out_valid(ov2), .out_data(od2));

  int     checks = 0, errors = 0;
  bit     cur_o2 = 1'b0;
  bit     mon_en = 1'b0;
  int     nout, sent;
  longint got [16];
  int     got_at [16];
  longint lastval;
  bit     r8_bad;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      longint v;
      bit ov;
      v  = cur_o2 ? longint'($signed(od2)) : longint'($signed(od5));
      ov = cur_o2 ? ov2 : ov5;
      if (ov) begin
        if (nout < 16) begin
          got[nout]    = v;
          got_at[nout] = sent;
        end
        nout++;
      end else if (v != lastval) begin
        r8_bad = 1'b1;
      end
      lastval = v;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0;
    rst = 1'b1; v5 = 1'b0; v2 = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    nout = 0; sent = 0; lastval = 0; r8_bad = 1'b0;
    mon_en = 1'b1;
  endtask

  function automatic longint floor_shift(input longint x, input int s);
    longint p;
    p = longint'(1) << s;
    if (x >= 0) return x / p;
    return -((-x + p - 1) / p);
  endfunction

  task automatic run_vec(input vec_t t, input string tag);
    int     lim_s, lim_r, s, r, ns, len;
    longint xin [192];
    longint xs  [192];
    longint h   [200];
    longint hn  [200];
    logic [15:0] lf;
    cur_o2 = t.o2;
    sc = t.sc;
    rm = t.rm1;
    do_reset();
    lim_s = t.o2 ? 6 : 20;
    lim_r = t.o2 ? 16 : 32;
    s = (int'(t.sc) > lim_s) ? lim_s : int'(t.sc);
    r = (int'(t.rm1) + 1 > lim_r) ? lim_r : int'(t.rm1) + 1;
    ns = NOUT * r;
    lf = t.amp | 16'h0001;
    for (int i = 0; i < ns; i++) begin
      logic [15:0] w;
      case (t.pat)
        2'd0:    w = t.amp;
        2'd1:    w = (i == 0) ? t.amp : 16'h0000;
        2'd2:    w = (i % 2 == 1) ? ~t.amp : t.amp;
        default: begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          w = lf;
        end
      endcase
      xin[i] = longint'($signed(w));
      xs[i]  = floor_shift(xin[i], s);
    end
    // impulse response of the boxcar raised to the order
    h[0] = 1; len = 1;
    for (int n = 0; n < (t.o2 ? 2 : 5); n++) begin
      for (int j = 0; j < len + r - 1; j++) begin
        hn[j] = 0;
        for (int k = 0; k < r; k++)
          if (j - k >= 0 && j - k < len) hn[j] += h[j-k];
      end
      len = len + r - 1;
      for (int j = 0; j < len; j++) h[j] = hn[j];
    end
    // drive samples, with optional idle gaps carrying garbage data
    for (int i = 0; i < ns; i++) begin
      din = 16'(xin[i]);
      if (t.o2) v2 = 1'b1; else v5 = 1'b1;
      @(posedge clk);
      sent++;
      @(negedge clk);
      v5 = 1'b0; v2 = 1'b0;
      if (t.gap) begin
        for (int g = 0; g < i % 3; g++) begin
          din = 16'h7FFF - 16'(i * 97);
          @(posedge clk);
          @(negedge clk);
        end
      end
    end
    repeat (3) @(negedge clk);
    chk(nout == NOUT, "R4", "output count", nout, NOUT);
    for (int k = 0; k < NOUT && k < nout; k++) begin
      longint e;
      int n;
      e = 0;
      n = (k + 1) * r - 1;
      for (int j = 0; j < len; j++)
        if (n - j >= 0) e += h[j] * xs[n-j];
      chk(got[k] == e, tag, $sformatf("output %0d value", k), got[k], e);
      chk(got_at[k] == (k + 1) * r, "R4", $sformatf("output %0d timing", k),
          got_at[k], (k + 1) * r);
    end
    chk(!r8_bad, "R8", "data held between strobes", r8_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run timed out", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: outputs quiet while reset is held
    repeat (3) @(negedge clk);
    chk(!ov5 && od5 == '0, "R1", "order-5 outputs in reset", longint'(od5), 0);
    chk(!ov2 && od2 == '0, "R1", "order-2 outputs in reset", longint'(od2), 0);
    rst = 1'b0;

    for (int v = 0; v < 13; v++) run_vec(VEC[v], vec_tag(v));

    // R1: reset in the middle of a run clears the history
    cur_o2 = 1'b0; sc = 5'd0; rm = 8'd3;
    for (int i = 0; i < 6; i++) begin
      din = 16'd7000; v5 = 1'b1;
      @(negedge clk);
    end
    v5 = 1'b0;
    do_reset();
    chk(!ov5 && od5 == '0, "R1", "outputs right after reset", longint'(od5), 0);
    run_vec(VEC[0], "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule